// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block collects the interrupt sources of a packet-buffered Ethernet MAC into one host-visible status byte, gates it with a host-written mask byte and drives a single interrupt line. Its sources are abort strobes from the receiver, the result of the transmit page allocator, the level of the transmit FIFO's empty flag, the empty flags of the transmit-completion and receive packet-number FIFOs, and the Ethernet protocol handler (EPH) events. The EPH events are statistics counter rollover and the fatal transmit errors.

Each status bit follows its own rule. Some bits are sticky and are cleared by a write-one acknowledge. Some are live complements of FIFO empty flags. The allocation bit tracks the allocator's latest result. The EPH bit is cleared only by side effects: a read of the counters, or turning the transmitter back on. An acknowledge of the transmit-done position returns a pop strobe, which removes the serviced packet number from the completion FIFO.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, `status_o`, `mask_o`, `irq_o` and `txc_pop_o` are all zero, provided both packet-number FIFOs report empty and the transmit FIFO does not.
- R2: Status bit 0 (receive) always equals the inverse of `rx_fifo_empty_i`, in the same cycle. An acknowledge write with bit 0 set has no effect on it.
- R3: Status bit 1 (transmit done) always equals the inverse of `txc_fifo_empty_i`. An acknowledge write with bit 1 set raises `txc_pop_o` combinationally, but only while that FIFO is not empty.
- R4: Status bit 2 (transmit idle) is set on the clock edge after `tx_fifo_empty_i` is seen high. It stays set until an acknowledge write with bit 2 set. If the FIFO is still empty when that acknowledge arrives, the bit stays set, so an acknowledge followed by a read gives the live state.
- R5: Status bit 3 (receive overrun) is set on the edge after any `rx_abort_i` bit pulses. The `rx_abort_i` bits are: 0 no buffer available, 1 frame over 2048 bytes, 2 discard requested. The bit is cleared only by an acknowledge write with bit 3 set. Acknowledge writes of other positions leave it set.
- R6: When a set event and an acknowledge of the same sticky bit fall in one cycle, the bit is set afterwards.
- R7: Status bit 4 (allocation done) takes the inverse of `alloc_fail_i` on the edge where `alloc_valid_i` is high. It is cleared on the edge where `alloc_req_i` is high without a result. A result wins over a request in the same cycle.
- R8: Status bit 5 (EPH) is set after `cnt_rollover_i` pulses, and that cause is cleared by `cnt_read_i`. A rollover wins over a read in the same cycle.
- R9: Any bit of `txerr_i` also sets status bit 5. The `txerr_i` bits are: 0 underrun, 1 SQE error, 2 lost carrier, 3 late collision, 4 sixteen collisions. This cause is cleared only on the edge after `tx_enable_i` rises. A counter read does not clear it.
- R10: `irq_o` is the OR of (`status_o` AND `mask_o`). A mask write takes effect on the next edge, and `irq_o` follows the registered mask in the same cycle.
- R11: Status bits 7 and 6 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fifo_empty_i | input | 1 | Receive packet-number FIFO empty |
| txc_fifo_empty_i | input | 1 | Transmit-completion FIFO empty |
| tx_fifo_empty_i | input | 1 | Transmit queue empty (level) |
| rx_abort_i | input | 3 | Receive abort strobes: no buffer, oversize, discard |
| alloc_req_i | input | 1 | Allocator started processing a new request |
| alloc_valid_i | input | 1 | Allocator result valid |
| alloc_fail_i | input | 1 | Allocator result failed |
| cnt_rollover_i | input | 1 | Statistics counter rolled over |
| cnt_read_i | input | 1 | Host read the counter register |
| txerr_i | input | 5 | Fatal transmit error strobes |
| tx_enable_i | input | 1 | Transmitter enable level |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_data_i | input | 8 | Acknowledge write data, one bit per status position |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | Mask write data |
| status_o | output | 8 | Status byte |
| mask_o | output | 8 | Current mask |
| irq_o | output | 1 | Interrupt request |
| txc_pop_o | output | 1 | Pop strobe to the transmit-completion FIFO |

## Verification
The receive and transmit-done bits, the pop strobe, and `irq_o`'s response to a registered mask are combinational. The bench checks these one time step after it drives the input, inside the same cycle. The sticky bits, the allocation bit, the EPH bit and the mask register have one register in the path, so they are checked just after the next rising edge. Every stimulus is driven a short delay after an edge and held for exactly one cycle. The bench samples a short delay after the following edge and before the next drive. Same-cycle races between an event and its clearing action are driven together on purpose, to confirm which one wins.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int STAT_W = 8;
    localparam int B_RX   = 0;
    localparam int B_TXD  = 1;
    localparam int B_TXE  = 2;
    localparam int B_OVF  = 3;
    localparam int B_ALC  = 4;
    localparam int B_EPH  = 5;

    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic              alloc;
    } ctl_t;

    typedef struct packed {
        logic cnt;
        logic fatal;
        logic txen_prev;
    } eph_t;
endpackage

// File: rtl/nic_irq_sticky.sv
module nic_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = set_i | (bit_q & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign q_o = bit_q;

    // R6: a set event beats a same-cycle acknowledge
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R5: a latched bit stays until acknowledged
    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/nic_irq_eph.sv
module nic_irq_eph #(
    parameter int NUM_ERR = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rollover_i,
    input  logic               cnt_read_i,
    input  logic [NUM_ERR-1:0] txerr_i,
    input  logic               tx_enable_i,
    output logic               eph_o
);
    import nic_irq_pkg::*;

    eph_t st_d, st_q;
    logic txen_rise;

    always_comb begin
        st_d           = st_q;
        txen_rise      = tx_enable_i & ~st_q.txen_prev;
        st_d.txen_prev = tx_enable_i;
        st_d.cnt       = rollover_i | (st_q.cnt & ~cnt_read_i);
        st_d.fatal     = (|txerr_i) | (st_q.fatal & ~txen_rise);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eph_o = st_q.cnt | st_q.fatal;

    // R8: a rollover raises the EPH indication on the next edge
    assert_eph_rollover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_i |=> eph_o);
    // R9: a fatal error raises the EPH indication on the next edge
    assert_eph_fatal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|txerr_i) |=> eph_o);
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
    parameter int NUM_RXABORT = 3,
    parameter int NUM_TXERR   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_fifo_empty_i,
    input  logic                   txc_fifo_empty_i,
    input  logic                   tx_fifo_empty_i,
    input  logic [NUM_RXABORT-1:0] rx_abort_i,
    input  logic                   alloc_req_i,
    input  logic                   alloc_valid_i,
    input  logic                   alloc_fail_i,
    input  logic                   cnt_rollover_i,
    input  logic                   cnt_read_i,
    input  logic [NUM_TXERR-1:0]   txerr_i,
    input  logic                   tx_enable_i,
    input  logic                   ack_we_i,
    input  logic [7:0]             ack_data_i,
    input  logic                   mask_we_i,
    input  logic [7:0]             mask_data_i,
    output logic [7:0]             status_o,
    output logic [7:0]             mask_o,
    output logic                   irq_o,
    output logic                   txc_pop_o
);
    import nic_irq_pkg::*;

    localparam logic [STAT_W-1:0] ACK_USED = STAT_W'((1 << B_TXD) | (1 << B_TXE) | (1 << B_OVF));

    ctl_t              ctl_d, ctl_q;
    logic [STAT_W-1:0] ack_v;
    logic              unused_ack;
    logic              txe_q, ovf_q, eph_q;
    logic [STAT_W-1:0] stat_c;

    assign ack_v      = ack_we_i ? (ack_data_i & ACK_USED) : '0;
    assign unused_ack = ^(ack_data_i & ~ACK_USED);

    nic_irq_sticky u_txe (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (tx_fifo_empty_i),
        .clr_i (ack_v[B_TXE]),
        .q_o   (txe_q)
    );

    nic_irq_sticky u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (|rx_abort_i),
        .clr_i (ack_v[B_OVF]),
        .q_o   (ovf_q)
    );

    nic_irq_eph #(.NUM_ERR(NUM_TXERR)) u_eph (
        .clk         (clk),
        .rst_n       (rst_n),
        .rollover_i  (cnt_rollover_i),
        .cnt_read_i  (cnt_read_i),
        .txerr_i     (txerr_i),
        .tx_enable_i (tx_enable_i),
        .eph_o       (eph_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (mask_we_i) ctl_d.mask = mask_data_i;
        if (alloc_valid_i)    ctl_d.alloc = ~alloc_fail_i;
        else if (alloc_req_i) ctl_d.alloc = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        stat_c        = '0;
        stat_c[B_RX]  = ~rx_fifo_empty_i;
        stat_c[B_TXD] = ~txc_fifo_empty_i;
        stat_c[B_TXE] = txe_q;
        stat_c[B_OVF] = ovf_q;
        stat_c[B_ALC] = ctl_q.alloc;
        stat_c[B_EPH] = eph_q;
    end

    assign status_o  = stat_c;
    assign mask_o    = ctl_q.mask;
    assign irq_o     = |(stat_c & ctl_q.mask);
    assign txc_pop_o = ack_v[B_TXD] & ~txc_fifo_empty_i;

    // R3: never pop an empty completion FIFO
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txc_pop_o |-> !txc_fifo_empty_i);
    // R7: a request without a result clears the allocation bit
    assert_alloc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_i && !alloc_valid_i) |=> !status_o[B_ALC]);
    // R7: a successful result sets the allocation bit
    assert_alloc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !alloc_fail_i) |=> status_o[B_ALC]);
    // R10: a written mask of zero silences the interrupt
    assert_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && mask_data_i == 8'h00) |=> !irq_o);
endmodule

// File: tb/tb_nic_irq_status.sv
`timescale 1ns/1ps
module tb_nic_irq_status;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_fifo_empty_i, txc_fifo_empty_i, tx_fifo_empty_i;
    logic [2:0] rx_abort_i;
    logic       alloc_req_i, alloc_valid_i, alloc_fail_i;
    logic       cnt_rollover_i, cnt_read_i;
    logic [4:0] txerr_i;
    logic       tx_enable_i, ack_we_i, mask_we_i;
    logic [7:0] ack_data_i, mask_data_i;
    logic [7:0] status_o, mask_o;
    logic       irq_o, txc_pop_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nic_irq_status dut (
        .clk(clk), .rst_n(rst_n),
        .rx_fifo_empty_i(rx_fifo_empty_i), .txc_fifo_empty_i(txc_fifo_empty_i),
        .tx_fifo_empty_i(tx_fifo_empty_i), .rx_abort_i(rx_abort_i),
        .alloc_req_i(alloc_req_i), .alloc_valid_i(alloc_valid_i), .alloc_fail_i(alloc_fail_i),
        .cnt_rollover_i(cnt_rollover_i), .cnt_read_i(cnt_read_i),
        .txerr_i(txerr_i), .tx_enable_i(tx_enable_i),
        .ack_we_i(ack_we_i), .ack_data_i(ack_data_i),
        .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
        .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o), .txc_pop_o(txc_pop_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO check FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        rx_abort_i = '0; alloc_req_i = 0; alloc_valid_i = 0; alloc_fail_i = 0;
        cnt_rollover_i = 0; cnt_read_i = 0; txerr_i = '0;
        ack_we_i = 0; ack_data_i = '0; mask_we_i = 0; mask_data_i = '0;
    endtask

    task automatic ack(input logic [7:0] v);
        ack_we_i = 1; ack_data_i = v; step(); ack_we_i = 0; ack_data_i = '0;
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h00);
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 pop", {7'd0, txc_pop_o}, 8'h00);
    endtask

    task automatic t_rx();
        rx_fifo_empty_i = 0; #1;
        chk("R2 rx live set", status_o & 8'h01, 8'h01);
        ack(8'h01);
        chk("R2 rx ack ignored", status_o & 8'h01, 8'h01);
        rx_fifo_empty_i = 1; #1;
        chk("R2 rx live clear", status_o & 8'h01, 8'h00);
    endtask

    task automatic t_txdone();
        txc_fifo_empty_i = 0; #1;
        chk("R3 txdone live", status_o & 8'h02, 8'h02);
        ack_we_i = 1; ack_data_i = 8'h02; #1;
        chk("R3 pop on ack", {7'd0, txc_pop_o}, 8'h01);
        txc_fifo_empty_i = 1; #1;
        chk("R3 no pop when empty", {7'd0, txc_pop_o}, 8'h00);
        chk("R3 txdone clear", status_o & 8'h02, 8'h00);
        step(); ack_we_i = 0; ack_data_i = '0;
    endtask

    task automatic t_txidle();
        tx_fifo_empty_i = 1; step(); tx_fifo_empty_i = 0;
        chk("R4 idle latched", status_o & 8'h04, 8'h04);
        step();
        chk("R4 idle holds", status_o & 8'h04, 8'h04);
        ack(8'h04);
        chk("R4 idle acked", status_o & 8'h04, 8'h00);
        tx_fifo_empty_i = 1; step();
        ack(8'h04);
        chk("R4 live empty re-sets", status_o & 8'h04, 8'h04);
        tx_fifo_empty_i = 0; ack(8'h04);
        chk("R4 clear after live low", status_o & 8'h04, 8'h00);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 3; i++) begin
            rx_abort_i = 3'b1 << i; step(); rx_abort_i = '0;
            chk("R5 overrun set", status_o & 8'h08, 8'h08);
            ack(8'hF7);
            chk("R5 other ack ignored", status_o & 8'h08, 8'h08);
            ack(8'h08);
            chk("R5 overrun cleared", status_o & 8'h08, 8'h00);
        end
    endtask

    task automatic t_setwins();
        rx_abort_i = 3'b010; ack_we_i = 1; ack_data_i = 8'h08; step();
        rx_abort_i = '0; ack_we_i = 0; ack_data_i = '0;
        chk("R6 set beats ack", status_o & 8'h08, 8'h08);
        ack(8'h08);
        chk("R6 later ack clears", status_o & 8'h08, 8'h00);
    endtask

    task automatic t_alloc();
        alloc_valid_i = 1; alloc_fail_i = 0; step(); alloc_valid_i = 0;
        chk("R7 alloc ok", status_o & 8'h10, 8'h10);
        alloc_req_i = 1; step(); alloc_req_i = 0;
        chk("R7 new request clears", status_o & 8'h10, 8'h00);
        alloc_valid_i = 1; alloc_req_i = 1; step(); alloc_valid_i = 0; alloc_req_i = 0;
        chk("R7 result beats request", status_o & 8'h10, 8'h10);
        alloc_valid_i = 1; alloc_fail_i = 1; step(); alloc_valid_i = 0; alloc_fail_i = 0;
        chk("R7 fail clears", status_o & 8'h10, 8'h00);
    endtask

    task automatic t_eph_cnt();
        cnt_rollover_i = 1; step(); cnt_rollover_i = 0;
        chk("R8 rollover sets", status_o & 8'h20, 8'h20);
        ack(8'h20);
        chk("R8 ack no effect", status_o & 8'h20, 8'h20);
        cnt_rollover_i = 1; cnt_read_i = 1; step(); cnt_rollover_i = 0;
        chk("R8 rollover beats read", status_o & 8'h20, 8'h20);
        step(); cnt_read_i = 0;
        chk("R8 read clears", status_o & 8'h20, 8'h00);
    endtask

    task automatic t_eph_fatal();
        for (int i = 0; i < 5; i++) begin
            txerr_i = 5'b1 << i; step(); txerr_i = '0;
            chk("R9 fatal sets", status_o & 8'h20, 8'h20);
            cnt_read_i = 1; step(); cnt_read_i = 0;
            chk("R9 read keeps fatal", status_o & 8'h20, 8'h20);
            tx_enable_i = 1; step();
            chk("R9 enable rise clears", status_o & 8'h20, 8'h00);
            tx_enable_i = 0; step();
        end
    endtask

    task automatic t_mask();
        rx_abort_i = 3'b001; step(); rx_abort_i = '0;
        #1 chk("R10 unmasked quiet", {7'd0, irq_o}, 8'h00);
        mask_we_i = 1; mask_data_i = 8'h08; step(); mask_we_i = 0;
        chk("R10 mask readback", mask_o, 8'h08);
        chk("R10 irq raised", {7'd0, irq_o}, 8'h01);
        mask_we_i = 1; mask_data_i = 8'h01; step(); mask_we_i = 0;
        chk("R10 other bit masked", {7'd0, irq_o}, 8'h00);
        rx_fifo_empty_i = 0; #1;
        chk("R10 rx unmasked irq", {7'd0, irq_o}, 8'h01);
        mask_we_i = 1; mask_data_i = 8'h00; step(); mask_we_i = 0;
        chk("R10 mask cleared", {7'd0, irq_o}, 8'h00);
        chk("R11 reserved zero", status_o & 8'hC0, 8'h00);
        rx_fifo_empty_i = 1; ack(8'h08);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("Watchdog FAIL: run hung, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0; rx_fifo_empty_i = 1; txc_fifo_empty_i = 1; tx_fifo_empty_i = 0; tx_enable_i = 0;
        repeat (3) step();
        rst_n = 1; step();
        t_reset();
        t_rx();
        t_txdone();
        t_txidle();
        t_overrun();
        t_setwins();
        t_alloc();
        t_eph_cnt();
        t_eph_fatal();
        t_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule